// File: doc/BRIEF.md
# BCD Real-Time Calendar Core

This core keeps wall-clock time and calendar date in packed BCD. It runs from a slow reference strobe (`rtc_en`, one pulse per RTC clock period, sampled in the `clk` domain). A two-stage divider, first a short asynchronous stage and then a long synchronous stage, turns that strobe into a one-second tick. Each tick advances seconds, minutes and 24-hour hours. At midnight the tick also advances the day of month, the weekday, the month and a two-digit year, and it follows month lengths and leap years.

Software stops the core by raising `init_req` and waits for `init_ack`. While the core is halted it can load a time word, a date word or a divider word. Any write that carries an illegal BCD field is dropped. The time and date words seen on the outputs are shadow copies. These are refreshed on every RTC pulse while the core runs. A ready flag, `sync_ok`, shows that the shadows have been refreshed twice since the last clear. The divider word is read back directly.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time word is 0x00000000. The date word is 0x00002101, which is day 01, month 01, weekday 1 and year 00. The divider word is 0x007F00FF (async 127, sync 255). `sync_ok` and `init_ack` are 0.
- R2: Time word layout: seconds in bits 6:0, minutes in bits 14:8, hours in bits 21:16. Date word layout: day in bits 5:0, month in bits 12:8, weekday in bits 15:13, year in bits 23:16. Divider word layout: sync value in bits 14:0, async value in bits 22:16. Every other bit of a written word is dropped and reads back as zero.
- R3: `init_ack` takes the value of `init_req` only at RTC pulses. A write selects its target with `wr_sel` (0 = time, 1 = date, 2 = divider, 3 = none). A write is accepted only while `init_ack` is 1 and is ignored otherwise.
- R4: After `init_ack` falls, the first tick comes on the (A+1)·(S+1)-th RTC pulse and the following ticks come every (A+1)·(S+1) pulses, where A is the async value and S is the sync value.
- R5: Seconds and minutes wrap from 59 to 00. Hours count from 00 to 23 and wrap to 00. Each BCD digit carries from 9 into the digit above it.
- R6: When hours wrap, the day of month advances and the weekday advances 1 to 7, then wraps back to 1.
- R7: A month ends after day 30 or day 31 as the calendar sets. February ends after day 29 when the year is divisible by 4 and after day 28 otherwise.
- R8: After month 12 the month becomes 01 and the year advances. Year 99 wraps to 00.
- R9: A time or date write is dropped as a whole in any of these cases: a digit above 9; a field out of range (seconds or minutes above 59, hours above 23, month outside 01–12, day outside 01 to the month's length, weekday 0, year above 99).
- R10: `sync_ok` is cleared while the core is halted, by `sync_clr`, and by an accepted write. After that it is set on the second RTC pulse that comes while the core runs. On each such pulse the shadow outputs copy the live counters as they were just before that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_en | input | 1 | One-cycle strobe per RTC clock period |
| init_req | input | 1 | Request to halt the core for loading |
| init_ack | output | 1 | Core is halted; writes are accepted |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 time, 1 date, 2 divider |
| wr_data | input | 32 | Write word |
| sync_clr | input | 1 | Clear the shadow-ready flag |
| time_o | output | 32 | Shadow time word |
| date_o | output | 32 | Shadow date word |
| presc_o | output | 32 | Divider word |
| sync_ok | output | 1 | Shadows refreshed since last clear |

## Verification
A tick lands in the live counters on the RTC pulse that completes the divider count. It shows on `time_o` and `date_o` only one pulse later, because the shadow copies the value held before each pulse. So, with both divider values at zero, j pulses after `init_ack` falls show j−1 ticks. `init_ack` changes on the pulse itself. `sync_ok` rises on the second running pulse. `presc_o` follows an accepted write on the next clock. The bench generates every RTC pulse itself and drives all inputs on falling clock edges. It samples only after a pulse sequence has ended, so each expected value comes from an exact count of pulses.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int PRESC_A_LSB = 16;

    typedef struct packed {
        logic [5:0] hr;
        logic [6:0] min;
        logic [6:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic [7:0] yr;
        logic [2:0] wd;
        logic [4:0] mon;
        logic [5:0] day;
    } cal_date_t;

    localparam cal_time_t TIME_RST = '0;
    localparam cal_date_t DATE_RST = '{yr: 8'h00, wd: 3'd1, mon: 5'h01, day: 6'h01};

    function automatic logic [31:0] time_word(cal_time_t t);
        return {10'd0, t.hr, 1'b0, t.min, 1'b0, t.sec};
    endfunction

    function automatic logic [31:0] date_word(cal_date_t d);
        return {8'd0, d.yr, d.wd, d.mon, 2'b00, d.day};
    endfunction

    function automatic cal_time_t time_field(logic [31:0] w);
        cal_time_t t;
        t.hr  = w[21:16];
        t.min = w[14:8];
        t.sec = w[6:0];
        return t;
    endfunction

    function automatic cal_date_t date_field(logic [31:0] w);
        cal_date_t d;
        d.yr  = w[23:16];
        d.wd  = w[15:13];
        d.mon = w[12:8];
        d.day = w[5:0];
        return d;
    endfunction

    // both digits decimal and value not above hi (BCD orders like binary)
    function automatic logic bcd_le(logic [7:0] v, logic [7:0] hi);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= hi);
    endfunction

    function automatic logic [7:0] bcd_inc(logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // divisible by 4: even tens with units 0/4/8, odd tens with units 2/6
    function automatic logic is_leap(logic [7:0] yr);
        if (yr[4] == 1'b0) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] month_last(logic [4:0] mon, logic [7:0] yr);
        case (mon)
            5'h02:                     return is_leap(yr) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                   return 8'h31;
        endcase
    endfunction

    function automatic logic time_ok(cal_time_t t);
        return bcd_le({1'b0, t.sec}, 8'h59) && bcd_le({1'b0, t.min}, 8'h59)
            && bcd_le({2'b0, t.hr}, 8'h23);
    endfunction

    function automatic logic date_ok(cal_date_t d);
        return bcd_le(d.yr, 8'h99) && (d.mon != 5'h0) && bcd_le({3'b0, d.mon}, 8'h12)
            && (d.day != 6'h0) && bcd_le({2'b0, d.day}, month_last(d.mon, d.yr))
            && (d.wd != 3'd0);
    endfunction

endpackage

// File: rtl/cal_presc.sv
module cal_presc
    import cal_pkg::*;
#(
    parameter int AW    = 7,
    parameter int SW    = 15,
    parameter int A_RST = 127,
    parameter int S_RST = 255
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rtc_en,
    input  logic        halted,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] presc_o,
    output logic        tick_o
);
    typedef struct packed {
        logic [AW-1:0] a_div;
        logic [SW-1:0] s_div;
        logic [AW-1:0] a_cnt;
        logic [SW-1:0] s_cnt;
    } ps_t;

    ps_t p_d, p_q;

    always_comb begin
        p_d    = p_q;
        tick_o = 1'b0;
        if (wr_en) begin
            p_d.s_div = wr_data[SW-1:0];
            p_d.a_div = wr_data[PRESC_A_LSB +: AW];
        end
        if (halted) begin
            p_d.a_cnt = p_d.a_div;
            p_d.s_cnt = p_d.s_div;
        end else if (rtc_en) begin
            if (p_q.a_cnt == '0) begin
                p_d.a_cnt = p_q.a_div;
                if (p_q.s_cnt == '0) begin
                    p_d.s_cnt = p_q.s_div;
                    tick_o    = 1'b1;
                end else begin
                    p_d.s_cnt = p_q.s_cnt - 1'b1;
                end
            end else begin
                p_d.a_cnt = p_q.a_cnt - 1'b1;
            end
        end
        presc_o = '0;
        presc_o[SW-1:0]            = p_q.s_div;
        presc_o[PRESC_A_LSB +: AW] = p_q.a_div;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.a_div <= AW'(A_RST);
            p_q.s_div <= SW'(S_RST);
            p_q.a_cnt <= AW'(A_RST);
            p_q.s_cnt <= SW'(S_RST);
        end else begin
            p_q <= p_d;
        end
    end

    // R4: running counters never exceed their reload values
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |-> (p_q.a_cnt <= p_q.a_div) && (p_q.s_cnt <= p_q.s_div));

endmodule

// File: rtl/cal_core.sv
module cal_core
    import cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_time,
    input  logic        wr_date,
    input  logic [31:0] wr_data,
    output cal_time_t   time_o,
    output cal_date_t   date_o
);
    typedef struct packed {
        cal_time_t t;
        cal_date_t d;
    } core_t;

    core_t s_d, s_q;
    logic [7:0] inc_sec, inc_min, inc_hr, inc_day, inc_mon, inc_yr, day_last;
    cal_time_t  w_time;
    cal_date_t  w_date;

    assign inc_sec  = bcd_inc({1'b0, s_q.t.sec});
    assign inc_min  = bcd_inc({1'b0, s_q.t.min});
    assign inc_hr   = bcd_inc({2'b0, s_q.t.hr});
    assign inc_day  = bcd_inc({2'b0, s_q.d.day});
    assign inc_mon  = bcd_inc({3'b0, s_q.d.mon});
    assign inc_yr   = bcd_inc(s_q.d.yr);
    assign day_last = month_last(s_q.d.mon, s_q.d.yr);
    assign w_time   = time_field(wr_data);
    assign w_date   = date_field(wr_data);

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (s_q.t.sec != 7'h59) begin
                s_d.t.sec = inc_sec[6:0];
            end else begin
                s_d.t.sec = '0;
                if (s_q.t.min != 7'h59) begin
                    s_d.t.min = inc_min[6:0];
                end else begin
                    s_d.t.min = '0;
                    if (s_q.t.hr != 6'h23) begin
                        s_d.t.hr = inc_hr[5:0];
                    end else begin
                        s_d.t.hr = '0;
                        s_d.d.wd = (s_q.d.wd == 3'd7) ? 3'd1 : s_q.d.wd + 3'd1;
                        if ({2'b0, s_q.d.day} != day_last) begin
                            s_d.d.day = inc_day[5:0];
                        end else begin
                            s_d.d.day = 6'h01;
                            if (s_q.d.mon != 5'h12) begin
                                s_d.d.mon = inc_mon[4:0];
                            end else begin
                                s_d.d.mon = 5'h01;
                                s_d.d.yr  = (s_q.d.yr == 8'h99) ? 8'h00 : inc_yr;
                            end
                        end
                    end
                end
            end
        end
        if (wr_time && time_ok(w_time)) s_d.t = w_time;
        if (wr_date && date_ok(w_date)) s_d.d = w_date;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.t <= TIME_RST;
            s_q.d <= DATE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign time_o = s_q.t;
    assign date_o = s_q.d;

    // R9: every stored digit stays decimal
    a_r9_digits_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_le({1'b0, s_q.t.sec}, 8'h59) && bcd_le({1'b0, s_q.t.min}, 8'h59)
        && bcd_le(s_q.d.yr, 8'h99) && bcd_le({3'b0, s_q.d.mon}, 8'h12));
    // R5: 24-hour range
    a_r5_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_le({2'b0, s_q.t.hr}, 8'h23));
    // R6: weekday stays 1..7
    a_r6_wday_range: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.d.wd != 3'd0));
    // R7: day never beyond the month's length
    a_r7_day_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.d.day != 6'h0) && ({2'b0, s_q.d.day} <= day_last));
    // R4: counters hold without a tick or a write
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_time && !wr_date) |=> $stable(s_q));

endmodule

// File: rtl/cal_sync.sv
module cal_sync
    import cal_pkg::*;
#(
    parameter int SYNC_EDGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rtc_en,
    input  logic        halted,
    input  logic        clr,
    input  logic [31:0] live_time,
    input  logic [31:0] live_date,
    output logic [31:0] time_o,
    output logic [31:0] date_o,
    output logic        sync_ok
);
    localparam int CW = $clog2(SYNC_EDGES + 1);

    typedef struct packed {
        logic [31:0]   sh_time;
        logic [31:0]   sh_date;
        logic [CW-1:0] cnt;
        logic          ok;
    } sy_t;

    sy_t y_d, y_q;

    always_comb begin
        y_d = y_q;
        if (clr || halted) begin
            y_d.ok  = 1'b0;
            y_d.cnt = '0;
        end else if (rtc_en) begin
            y_d.sh_time = live_time;
            y_d.sh_date = live_date;
            if (!y_q.ok) begin
                if (y_q.cnt == CW'(SYNC_EDGES - 1)) begin
                    y_d.ok  = 1'b1;
                    y_d.cnt = '0;
                end else begin
                    y_d.cnt = y_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q.sh_time <= time_word(TIME_RST);
            y_q.sh_date <= date_word(DATE_RST);
            y_q.cnt     <= '0;
            y_q.ok      <= 1'b0;
        end else begin
            y_q <= y_d;
        end
    end

    assign time_o  = y_q.sh_time;
    assign date_o  = y_q.sh_date;
    assign sync_ok = y_q.ok;

    // R10: flag drops after a clear or while halted
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || halted) |=> !sync_ok);
    // R10: shadows move only on RTC pulses
    a_r10_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rtc_en |=> ($stable(time_o) && $stable(date_o)));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int ASYNC_W    = 7,
    parameter int SYNC_W     = 15,
    parameter int ASYNC_RST  = 127,
    parameter int SYNC_RST   = 255,
    parameter int SYNC_EDGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rtc_en,
    input  logic        init_req,
    output logic        init_ack,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        sync_clr,
    output logic [31:0] time_o,
    output logic [31:0] date_o,
    output logic [31:0] presc_o,
    output logic        sync_ok
);
    logic      ack_d, ack_q;
    logic      wr_acc, wr_time, wr_date, wr_presc, tick;
    cal_time_t live_t;
    cal_date_t live_d;

    always_comb begin
        ack_d = rtc_en ? init_req : ack_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack_d;
    end

    assign init_ack = ack_q;
    assign wr_acc   = wr_en && ack_q;
    assign wr_time  = wr_acc && (wr_sel == 2'd0);
    assign wr_date  = wr_acc && (wr_sel == 2'd1);
    assign wr_presc = wr_acc && (wr_sel == 2'd2);

    cal_presc #(
        .AW(ASYNC_W), .SW(SYNC_W), .A_RST(ASYNC_RST), .S_RST(SYNC_RST)
    ) u_presc (
        .clk(clk), .rst_n(rst_n), .rtc_en(rtc_en), .halted(ack_q),
        .wr_en(wr_presc), .wr_data(wr_data), .presc_o(presc_o), .tick_o(tick)
    );

    cal_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_time(wr_time),
        .wr_date(wr_date), .wr_data(wr_data), .time_o(live_t), .date_o(live_d)
    );

    cal_sync #(.SYNC_EDGES(SYNC_EDGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rtc_en(rtc_en), .halted(ack_q),
        .clr(sync_clr || wr_acc), .live_time(time_word(live_t)),
        .live_date(date_word(live_d)), .time_o(time_o), .date_o(date_o),
        .sync_ok(sync_ok)
    );

    // R3: handshake moves only on RTC pulses
    a_r3_ack_on_rtc: assert property (@(posedge clk) disable iff (!rst_n)
        !rtc_en |=> $stable(init_ack));
    // R3: divider word frozen while running
    a_r3_presc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !init_ack |=> $stable(presc_o));

endmodule

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_en = 1'b0, init_req = 1'b0, wr_en = 1'b0, sync_clr = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic        init_ack, sync_ok;
    logic [31:0] time_o, date_o, presc_o;

    int n_chk = 0, n_fail = 0;
    int m_s, m_m, m_h, m_dd, m_mo, m_wd, m_y;
    bit fresh;

    always #10 clk = ~clk;

    bcd_calendar u_dut (
        .clk(clk), .rst_n(rst_n), .rtc_en(rtc_en), .init_req(init_req),
        .init_ack(init_ack), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sync_clr(sync_clr), .time_o(time_o), .date_o(date_o),
        .presc_o(presc_o), .sync_ok(sync_ok)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] exp_time();
        return 32'(((m_h / 10) << 20) | ((m_h % 10) << 16) | ((m_m / 10) << 12)
                 | ((m_m % 10) << 8) | ((m_s / 10) << 4) | (m_s % 10));
    endfunction

    function automatic logic [31:0] exp_date();
        return 32'(((m_y / 10) << 20) | ((m_y % 10) << 16) | (m_wd << 13)
                 | ((m_mo / 10) << 12) | ((m_mo % 10) << 8) | ((m_dd / 10) << 4) | (m_dd % 10));
    endfunction

    task automatic step();
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_m++;
            if (m_m == 60) begin
                m_m = 0; m_h++;
                if (m_h == 24) begin
                    m_h = 0;
                    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                    m_dd++;
                    if (m_dd > dim(m_mo, m_y)) begin
                        m_dd = 1; m_mo++;
                        if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic rtc_pulse();
        @(negedge clk) rtc_en = 1'b1;
        @(negedge clk) rtc_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        @(negedge clk) begin wr_en = 1'b1; wr_sel = sel; wr_data = data; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic enter_init();
        @(negedge clk) init_req = 1'b1;
        rtc_pulse();
    endtask

    task automatic exit_init();
        @(negedge clk) init_req = 1'b0;
        rtc_pulse();
        fresh = 1'b1;
    endtask

    task automatic set_model(int h, int mi, int s, int d, int mo, int wd, int y);
        m_h = h; m_m = mi; m_s = s; m_dd = d; m_mo = mo; m_wd = wd; m_y = y;
    endtask

    task automatic load(int h, int mi, int s, int d, int mo, int wd, int y, int a, int sd);
        set_model(h, mi, s, d, mo, wd, y);
        enter_init();
        wr(2'd2, 32'((a << 16) | sd));
        wr(2'd0, exp_time());
        wr(2'd1, exp_date());
        exit_init();
    endtask

    // with both dividers at zero every running pulse ticks; shadow lags one pulse
    task automatic advance(int j);
        repeat (j) rtc_pulse();
        repeat (fresh ? j - 1 : j) step();
        fresh = 1'b0;
    endtask

    task automatic cmp(string req);
        chk({req, " time"}, time_o, exp_time());
        chk({req, " date"}, date_o, exp_date());
    endtask

    task automatic t_reset();
        chk("R1 time", time_o, 32'h0);
        chk("R1 date", date_o, 32'h0000_2101);
        chk("R1 presc", presc_o, 32'h007F_00FF);
        chk("R1 sync_ok", {31'd0, sync_ok}, 32'd0);
        chk("R1 init_ack", {31'd0, init_ack}, 32'd0);
    endtask

    task automatic t_handshake();
        @(negedge clk) init_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 ack waits for pulse", {31'd0, init_ack}, 32'd0);
        rtc_pulse();
        chk("R3 ack on pulse", {31'd0, init_ack}, 32'd1);
        chk("R10 halted clears flag", {31'd0, sync_ok}, 32'd0);
        wr(2'd2, 32'h0000_0000);
        chk("R2 presc write", presc_o, 32'h0);
        set_model(10, 20, 30, 14, 7, 2, 31);
        wr(2'd0, exp_time());
        wr(2'd1, exp_date());
        @(negedge clk) init_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 ack held until pulse", {31'd0, init_ack}, 32'd1);
        rtc_pulse();
        chk("R3 ack falls on pulse", {31'd0, init_ack}, 32'd0);
        rtc_pulse();
        chk("R10 not ready after one pulse", {31'd0, sync_ok}, 32'd0);
        rtc_pulse();
        chk("R10 ready after two pulses", {31'd0, sync_ok}, 32'd1);
        step();
        fresh = 1'b0;
        cmp("R10 shadow");
        @(negedge clk) sync_clr = 1'b1;
        @(negedge clk) sync_clr = 1'b0;
        chk("R10 sync_clr clears", {31'd0, sync_ok}, 32'd0);
        rtc_pulse();
        chk("R10 still clear", {31'd0, sync_ok}, 32'd0);
        rtc_pulse();
        chk("R10 ready again", {31'd0, sync_ok}, 32'd1);
        repeat (2) step();
        cmp("R10 shadow after clear");
    endtask

    task automatic t_carry();
        load(12, 34, 58, 15, 6, 3, 24, 0, 0);
        advance(4);
        cmp("R5 minute carry");
        load(9, 59, 58, 15, 6, 3, 24, 0, 0);
        advance(3);
        cmp("R5 hour digit carry");
        load(23, 59, 59, 10, 3, 7, 25, 0, 0);
        advance(2);
        cmp("R6 midnight weekday wrap");
    endtask

    task automatic t_month();
        load(23, 59, 59, 28, 2, 1, 23, 0, 0);
        advance(2);
        cmp("R7 Feb 28 common year");
        load(23, 59, 59, 28, 2, 1, 24, 0, 0);
        advance(2);
        cmp("R7 Feb 28 leap year");
        load(23, 59, 59, 29, 2, 4, 24, 0, 0);
        advance(2);
        cmp("R7 Feb 29 leap year");
        load(23, 59, 59, 30, 4, 5, 26, 0, 0);
        advance(2);
        cmp("R7 30-day month");
        load(23, 59, 59, 30, 1, 5, 26, 0, 0);
        advance(2);
        cmp("R7 31-day month");
        load(23, 59, 59, 31, 12, 6, 99, 0, 0);
        advance(2);
        cmp("R8 year wrap");
    endtask

    task automatic t_ignored();
        load(5, 6, 7, 8, 9, 2, 10, 0, 0);
        advance(2);
        wr(2'd0, 32'h0000_0000);
        wr(2'd1, 32'h0012_2131);
        wr(2'd2, 32'h0003_0003);
        chk("R3 running presc write ignored", presc_o, 32'h0);
        advance(2);
        cmp("R3 running writes ignored");
    endtask

    task automatic t_invalid();
        set_model(1, 2, 3, 4, 5, 6, 7);
        enter_init();
        wr(2'd0, exp_time());
        wr(2'd1, exp_date());
        wr(2'd0, 32'h0001_0A03);
        wr(2'd0, 32'h0024_0000);
        wr(2'd1, 32'h0007_3304);
        wr(2'd1, 32'h0023_4230);
        wr(2'd1, 32'h0007_0504);
        exit_init();
        advance(2);
        cmp("R9 invalid writes dropped");
    endtask

    task automatic t_mask();
        enter_init();
        wr(2'd0, 32'hFF12_34D6);
        wr(2'd1, 32'hFF24_26D5);
        wr(2'd2, 32'hFFFF_FFFF);
        chk("R2 presc masked", presc_o, 32'h007F_7FFF);
        wr(2'd2, 32'h0000_0000);
        exit_init();
        set_model(12, 34, 56, 15, 6, 1, 24);
        advance(2);
        cmp("R2 reserved bits dropped");
    endtask

    task automatic t_presc();
        load(0, 0, 0, 1, 1, 1, 0, 1, 2);
        chk("R2 presc layout", presc_o, 32'h0001_0002);
        repeat (6) rtc_pulse();
        cmp("R4 no tick before 6 pulses");
        rtc_pulse();
        step();
        cmp("R4 tick on 6th pulse");
        repeat (6) rtc_pulse();
        step();
        cmp("R4 next tick 6 pulses later");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_carry();
        t_month();
        t_ignored();
        t_invalid();
        t_mask();
        t_presc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule